// File: doc/BRIEF.md
# Hold-Mode Standby and Wake Sequencer

This block governs a deep standby mode of a small microcontroller core. A one-cycle hold request from the instruction decoder puts the core into standby, but only while an external active-low hold pin is held low. Otherwise the request is dropped. While in standby, the core clock is gated off. Raising the hold pin wakes the core. Every wake, and every accepted reset, runs through a fixed oscillator stabilisation count before the core clock is enabled again.

The external reset pin is qualified by the hold pin. A low reset pin initialises the core only while the hold pin is high, and is ignored while the hold pin is low. Both pins pass through two-flop synchronisers before any decision uses them. An accepted reset acts as the synchronous active-high reset of the sequencer itself. On each entry to the stabilisation wait, the block presents a load strobe and a preset value for the core's 12-bit timer.

Top module: `hold_wake_seq`

## Requirements
- R1: In the RUN state, a `hold_req` strobe seen together with a synchronised low hold pin moves the sequencer to HOLD at that clock edge. With the hold pin high, the strobe is ignored and the state stays RUN.
- R2: In HOLD, a synchronised high hold pin moves the sequencer to WAIT at the next edge, and the wait counter is cleared.
- R3: WAIT lasts exactly `1 << WAIT_W` cycles (16384 by default), after which the state becomes RUN. RUN is entered only from WAIT.
- R4: A low reset pin has no effect while the hold pin is low: the state and `core_rst` are unchanged.
- R5: A low reset pin with the hold pin high forces WAIT, clears the wait count and raises `core_rst`. `core_rst` stays high until that wait ends. A wake from HOLD does not raise `core_rst`.
- R6: `tmr_load` is high in the cycle after each entry into WAIT, and in every cycle while a reset is being accepted. At those times `tmr_val` is 0xFFC.
- R7: `core_clk_en` is high only in RUN. `osc_wait` is high exactly in WAIT.
- R8: Each pin is seen through two synchronising flops. A change made after one edge is acted on at the third edge.
- R9: `hold_req` has no effect in HOLD or WAIT.
- R10: `seq_state` shows the state with the encoding RUN=0, HOLD=1, WAIT=2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_pin_n | input | 1 | External reset pin, active low, asynchronous to clk |
| hold_pin_n | input | 1 | External hold pin; low permits standby, high wakes |
| hold_req | input | 1 | One-cycle standby request from the instruction decoder |
| core_clk_en | output | 1 | Core clock-gate enable |
| core_rst | output | 1 | Core reset, active high |
| osc_wait | output | 1 | High while the stabilisation count runs |
| tmr_load | output | 1 | Load strobe for the 12-bit timer |
| tmr_val | output | 12 | Value to load into the timer (0xFFC) |
| seq_state | output | 2 | Current sequencer state (RUN=0, HOLD=1, WAIT=2) |

## Verification
The properties assume that the hold request is a single-cycle strobe from logic on the same clock. They also assume that the sequencer has seen at least one accepted reset before it is judged, because the synchronisers and state hold no defined value before that. The bench opens with a reset that is held low for several cycles with the hold pin high. It changes pins only between edges and holds each level for at least two cycles, so that every change passes through both synchroniser flops. The assertions are switched off during accepted resets.

// File: rtl/hws_pkg.sv
package hws_pkg;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_HOLD = 2'd1,
        ST_WAIT = 2'd2
    } hws_state_e;

    typedef struct packed {
        logic clk_en;
        logic osc_wait;
    } hws_gate_t;

    localparam int unsigned DEF_WAIT_W  = 14;
    localparam int unsigned DEF_TMR_W   = 12;
    localparam int unsigned DEF_SYNC_N  = 2;
    localparam logic [11:0] DEF_PRESET  = 12'hFFC;

    function automatic hws_gate_t gate_of(input hws_state_e st);
        hws_gate_t g;
        g.clk_en   = (st == ST_RUN);
        g.osc_wait = (st == ST_WAIT);
        return g;
    endfunction

endpackage

// File: rtl/hws_sync.sv
module hws_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic d_in,
    output logic q_out
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) chain[0] <= d_in;
            end else begin : g_next
                always_ff @(posedge clk) chain[i] <= chain[i-1];
            end
        end
    endgenerate

    assign q_out = chain[STAGES-1];
endmodule

// File: rtl/hws_wait_cnt.sv
module hws_wait_cnt #(
    parameter int unsigned WAIT_W = 14
) (
    input  logic              clk,
    input  logic              clr,
    input  logic              run,
    output logic [WAIT_W-1:0] cnt,
    output logic              done
);
    localparam logic [WAIT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (clr)
            cnt <= '0;
        else if (run)
            cnt <= cnt + 1'b1;
    end

    assign done = run && !clr && (cnt == CNT_MAX);
endmodule

// File: rtl/hws_fsm.sv
module hws_fsm
    import hws_pkg::*;
(
    input  logic       clk,
    input  logic       rst_valid,
    input  logic       hold_hi,
    input  logic       hold_req,
    input  logic       wait_done,
    output hws_state_e state,
    output logic       core_rst,
    output logic       tmr_load,
    output logic       cnt_clr
);
    logic wake;

    assign wake    = (state == ST_HOLD) && hold_hi;
    assign cnt_clr = rst_valid || wake;

    always_ff @(posedge clk) begin
        if (rst_valid) begin
            state    <= ST_WAIT;
            core_rst <= 1'b1;
            tmr_load <= 1'b1;
        end else begin
            tmr_load <= 1'b0;
            unique case (state)
                ST_RUN: begin
                    if (hold_req && !hold_hi)
                        state <= ST_HOLD;
                end
                ST_HOLD: begin
                    if (hold_hi) begin
                        state    <= ST_WAIT;
                        tmr_load <= 1'b1;
                    end
                end
                ST_WAIT: begin
                    if (wait_done) begin
                        state    <= ST_RUN;
                        core_rst <= 1'b0;
                    end
                end
                default: state <= ST_WAIT;
            endcase
        end
    end
endmodule

// File: rtl/hold_wake_seq.sv
module hold_wake_seq
    import hws_pkg::*;
#(
    parameter int unsigned WAIT_W = DEF_WAIT_W,
    parameter int unsigned TMR_W  = DEF_TMR_W,
    parameter int unsigned SYNC_N = DEF_SYNC_N,
    parameter logic [TMR_W-1:0] PRESET = TMR_W'(DEF_PRESET)
) (
    input  logic             clk,
    input  logic             rst_pin_n,
    input  logic             hold_pin_n,
    input  logic             hold_req,
    output logic             core_clk_en,
    output logic             core_rst,
    output logic             osc_wait,
    output logic             tmr_load,
    output logic [TMR_W-1:0] tmr_val,
    output logic [1:0]       seq_state
);
    logic              rst_s;
    logic              hold_s;
    logic              rst_valid;
    logic              cnt_clr;
    logic              wait_done;
    logic [WAIT_W-1:0] wait_cnt;
    hws_state_e        state;
    hws_gate_t         gate;

    hws_sync #(.STAGES(SYNC_N)) u_sync_rst (
        .clk(clk), .d_in(rst_pin_n), .q_out(rst_s)
    );
    hws_sync #(.STAGES(SYNC_N)) u_sync_hold (
        .clk(clk), .d_in(hold_pin_n), .q_out(hold_s)
    );

    // reset acts only while the hold pin is high
    assign rst_valid = !rst_s && hold_s;

    hws_fsm u_fsm (
        .clk       (clk),
        .rst_valid (rst_valid),
        .hold_hi   (hold_s),
        .hold_req  (hold_req),
        .wait_done (wait_done),
        .state     (state),
        .core_rst  (core_rst),
        .tmr_load  (tmr_load),
        .cnt_clr   (cnt_clr)
    );

    hws_wait_cnt #(.WAIT_W(WAIT_W)) u_cnt (
        .clk  (clk),
        .clr  (cnt_clr),
        .run  (state == ST_WAIT),
        .cnt  (wait_cnt),
        .done (wait_done)
    );

    assign gate        = gate_of(state);
    assign core_clk_en = gate.clk_en;
    assign osc_wait    = gate.osc_wait;
    assign tmr_val     = PRESET;
    assign seq_state   = state;
endmodule

// File: rtl/hws_chk.sv
module hws_chk #(
    parameter int unsigned WAIT_W = 14,
    parameter int unsigned TMR_W  = 12,
    parameter logic [TMR_W-1:0] PRESET = '1
) (
    input logic              clk,
    input logic              rst_valid,
    input logic              rst_s,
    input logic              hold_s,
    input logic              hold_req,
    input logic              wait_done,
    input logic [WAIT_W-1:0] wait_cnt,
    input logic [1:0]        seq_state,
    input logic              core_clk_en,
    input logic              core_rst,
    input logic              osc_wait,
    input logic              tmr_load,
    input logic [TMR_W-1:0]  tmr_val
);
    logic armed = 1'b0;
    always_ff @(posedge clk) if (rst_valid) armed <= 1'b1;

    AST_HOLD_NEEDS_PIN: assert property (@(posedge clk) disable iff (rst_valid || !armed)
        (seq_state == 2'd1 && $past(seq_state) == 2'd0) |-> ($past(hold_req) && !$past(hold_s))); // R1
    AST_WAKE_ON_PIN: assert property (@(posedge clk) disable iff (rst_valid || !armed)
        (seq_state == 2'd2 && $past(seq_state) == 2'd1) |-> $past(hold_s)); // R2
    AST_RUN_ONLY_FROM_WAIT: assert property (@(posedge clk) disable iff (rst_valid || !armed)
        (seq_state == 2'd0 && $past(seq_state) != 2'd0) |-> ($past(seq_state) == 2'd2 && $past(wait_done))); // R3
    AST_DONE_ENDS_WAIT: assert property (@(posedge clk) disable iff (rst_valid || !armed)
        wait_done |=> (seq_state == 2'd0 || rst_valid)); // R3
    AST_RST_QUALIFIED: assert property (@(posedge clk) disable iff (rst_valid || !armed)
        $rose(core_rst) |-> ($past(hold_s) && !$past(rst_s))); // R4
    AST_RST_UNTIL_RUN: assert property (@(posedge clk) disable iff (rst_valid || !armed)
        $fell(core_rst) |-> (seq_state == 2'd0)); // R5
    AST_CNT_CLEARED: assert property (@(posedge clk) disable iff (rst_valid || !armed)
        $rose(osc_wait) |-> (wait_cnt == '0)); // R2
    AST_LOAD_ON_ENTRY: assert property (@(posedge clk) disable iff (rst_valid || !armed)
        $rose(osc_wait) |-> (tmr_load && tmr_val == PRESET)); // R6
    AST_GATE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst_valid || !armed)
        !(core_clk_en && osc_wait)); // R7
    AST_NO_REQ_EFFECT: assert property (@(posedge clk) disable iff (rst_valid || !armed)
        ($past(seq_state) == 2'd1 && !$past(hold_s)) |-> (seq_state == 2'd1)); // R9
endmodule

bind hold_wake_seq hws_chk #(.WAIT_W(WAIT_W), .TMR_W(TMR_W), .PRESET(PRESET)) u_chk (
    .clk(clk), .rst_valid(rst_valid), .rst_s(rst_s), .hold_s(hold_s),
    .hold_req(hold_req), .wait_done(wait_done), .wait_cnt(wait_cnt),
    .seq_state(seq_state), .core_clk_en(core_clk_en), .core_rst(core_rst),
    .osc_wait(osc_wait), .tmr_load(tmr_load), .tmr_val(tmr_val)
);

// File: tb/tb_hold_wake_seq.sv
module tb_hold_wake_seq;
    localparam int WAITC = 16384;
    localparam int SYNC  = 2;

    logic clk = 1'b0;
    logic rst_pin_n, hold_pin_n, hold_req;
    logic core_clk_en, core_rst, osc_wait, tmr_load;
    logic [11:0] tmr_val;
    logic [1:0]  seq_state;

    int n_run = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done_flag = 1'b0;

    always #2 clk = ~clk;

    hold_wake_seq dut (
        .clk(clk), .rst_pin_n(rst_pin_n), .hold_pin_n(hold_pin_n), .hold_req(hold_req),
        .core_clk_en(core_clk_en), .core_rst(core_rst), .osc_wait(osc_wait),
        .tmr_load(tmr_load), .tmr_val(tmr_val), .seq_state(seq_state)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=0", cyc);
            finish_run();
        end
    end

    // counts edges from now until the clock enable rises
    task automatic to_run(input int start, output int n);
        n = start;
        while (!core_clk_en && n < 20000) begin
            tick();
            n++;
        end
    endtask

    initial begin
        int n;
        rst_pin_n = 1'b1; hold_pin_n = 1'b1; hold_req = 1'b0;
        repeat (3) tick();

        // accepted reset
        rst_pin_n = 1'b0;
        repeat (5) tick();
        chk("R5 state WAIT on reset", seq_state, 2);
        chk("R5 core_rst high", core_rst, 1);
        chk("R7 clk_en low in WAIT", core_clk_en, 0);
        chk("R7 osc_wait high in WAIT", osc_wait, 1);
        chk("R6 tmr_load while reset", tmr_load, 1);
        chk("R6 tmr_val preset", tmr_val, 12'hFFC);
        rst_pin_n = 1'b1;
        to_run(0, n);
        chk("R3 reset wait length", n, SYNC + WAITC);
        chk("R10 RUN code", seq_state, 0);
        chk("R5 core_rst released", core_rst, 0);
        chk("R7 osc_wait low in RUN", osc_wait, 0);
        chk("R6 tmr_load idle", tmr_load, 0);

        // R1 ignored with pin high (sweep of strobe patterns)
        for (int k = 0; k < 4; k++) begin
            hold_req = 1'b1;
            repeat (k + 1) tick();
            hold_req = 1'b0;
            tick();
            chk("R1 req ignored pin high", seq_state, 0);
        end

        // R1 enter hold
        hold_pin_n = 1'b0;
        repeat (3) tick();
        hold_req = 1'b1;
        tick();
        hold_req = 1'b0;
        chk("R1 enter HOLD", seq_state, 1);
        chk("R7 clk_en low in HOLD", core_clk_en, 0);
        chk("R7 osc_wait low in HOLD", osc_wait, 0);
        hold_req = 1'b1;
        tick();
        hold_req = 1'b0;
        repeat (3) tick();
        chk("R9 req in HOLD no effect", seq_state, 1);

        // R4 reset ignored while hold pin low
        rst_pin_n = 1'b0;
        repeat (10) tick();
        chk("R4 reset ignored state", seq_state, 1);
        chk("R4 reset ignored core_rst", core_rst, 0);
        rst_pin_n = 1'b1;
        repeat (3) tick();

        // R8 / R2 wake
        hold_pin_n = 1'b1;
        tick(); tick();
        chk("R8 two-stage latency", seq_state, 1);
        tick();
        chk("R2 wake to WAIT", seq_state, 2);
        chk("R6 tmr_load on wake", tmr_load, 1);
        chk("R5 no core_rst on wake", core_rst, 0);
        n = 3;
        while (!core_clk_en && n < 20000) begin
            if (n == 50) hold_pin_n = 1'b0;
            hold_req = (n == 60);
            tick();
            n++;
            if (n == 70) chk("R9 req in WAIT no effect", seq_state, 2);
        end
        hold_req = 1'b0;
        chk("R3 wake wait length", n, SYNC + 1 + WAITC);
        chk("R3 RUN after wake", seq_state, 0);

        // R1 second entry, then wake and reset inside WAIT
        hold_req = 1'b1;
        tick();
        hold_req = 1'b0;
        chk("R1 second HOLD entry", seq_state, 1);
        hold_pin_n = 1'b1;
        repeat (200) tick();
        chk("R2 second wake WAIT", seq_state, 2);
        rst_pin_n = 1'b0;
        repeat (4) tick();
        chk("R5 reset during WAIT", core_rst, 1);
        rst_pin_n = 1'b1;
        to_run(0, n);
        chk("R5 restarted wait length", n, SYNC + WAITC);
        chk("R5 core_rst cleared at RUN", core_rst, 0);

        finish_run();
    end
endmodule